// File: doc/BRIEF.md
# Cell Stream Loopback Controller

This block sits where a cell handler meets its transmission-convergence stage and moves whole cells among three sources and three sinks. The sources are the transmit cell buffer, the handler's finished transmit stream and the line-side receive stream. The sinks are the handler's transmit input, the line transmit output and the handler's receive input. Three loopback taps can redirect traffic. The first tap turns buffer cells back toward the receive handler. The second tap turns the handler's transmit output, idle and unassigned cells included, back to the receive handler. The third tap turns line receive cells back toward the line transmit output.

Each tap has its own 2-bit setting. The tap can be off, loop only, or loop and forward. In loop-and-forward mode a source sends each cell to two sinks and moves on only after both sinks have accepted the byte. Sinks are granted one whole cell at a time, so cells never interleave. When two sources compete for the same sink, a looping source wins and the other source is stalled with backpressure. No cell is dropped.

Every stream is byte-wide and uses valid/ready handshaking. A start-of-cell flag marks byte 0 of each cell of `CELL_BYTES` bytes (53 by default). The buffer port is first-word-fall-through: while the empty flag is low, the data is valid, and a read-enable pulse pops one byte.

Top module: `cell_loop_ctrl`

## Requirements
- R1: Each tap setting is decoded as 00 = off, 01 = loop only, 10 = loop and forward. The value 11 behaves exactly like 00.
- R2: With every tap off, buffer cells go to the handler transmit input, handler transmit output cells go to the line transmit output, and line receive cells go to the handler receive input. Every cell keeps its byte order.
- R3: With the buffer tap in loop-only mode, buffer cells appear on the handler receive input and not on the handler transmit input. The buffer is read whenever it is not empty.
- R4: With the handler-output tap in loop-only mode, every cell of that stream reaches the handler receive input and none reaches the line transmit output. This includes idle cells.
- R5: With the line-receive tap in loop-only mode, line cells reach the line transmit output and none reaches the handler receive input.
- R6: In loop-and-forward mode, each cell reaches both the normal sink and the loopback sink unchanged. The source advances past a byte only after both sinks have taken it, so a stalled sink holds the other sink at that byte.
- R7: Each sink carries only whole cells of `CELL_BYTES` bytes, with the start flag high on byte 0 and only there. Cells from different sources never interleave on a sink. A tap setting changed while a cell is in flight applies from that source's next cell.
- R8: When several sources want the same free sink, sources whose tap is looping win over sources whose tap is off. Ties go in the order buffer, handler transmit output, line receive.
- R9: A source that loses arbitration, or whose sink is not ready, sees its ready (or read enable) held low and loses no data. A sink's valid byte stays stable until it is accepted.
- R10: The receive tap and the transmit taps work at the same time without disturbing each other. With both the handler-output tap and the line-receive tap looping, both sinks can transfer in the same cycle.
- R11: While reset is asserted, no sink is valid and the buffer is not read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tap_buf | input | 2 | Buffer tap setting |
| cfg_tap_txo | input | 2 | Handler-output tap setting |
| cfg_tap_rxl | input | 2 | Line-receive tap setting |
| buf_data | input | DATA_W | Buffer head byte |
| buf_empty | input | 1 | Buffer has no data |
| buf_rd | output | 1 | Pop one buffer byte |
| txo_data | input | DATA_W | Handler transmit output byte |
| txo_soc | input | 1 | Start of cell on handler transmit output |
| txo_valid | input | 1 | Handler transmit output byte valid |
| txo_ready | output | 1 | Handler transmit output byte accepted |
| rxl_data | input | DATA_W | Line receive byte |
| rxl_soc | input | 1 | Start of cell on line receive |
| rxl_valid | input | 1 | Line receive byte valid |
| rxl_ready | output | 1 | Line receive byte accepted |
| hti_data | output | DATA_W | Handler transmit input byte |
| hti_soc | output | 1 | Start of cell to handler transmit input |
| hti_valid | output | 1 | Handler transmit input byte valid |
| hti_ready | input | 1 | Handler transmit input accepts |
| ltx_data | output | DATA_W | Line transmit byte |
| ltx_soc | output | 1 | Start of cell to line transmit |
| ltx_valid | output | 1 | Line transmit byte valid |
| ltx_ready | input | 1 | Line transmit accepts |
| hrx_data | output | DATA_W | Handler receive byte |
| hrx_soc | output | 1 | Start of cell to handler receive |
| hrx_valid | output | 1 | Handler receive byte valid |
| hrx_ready | input | 1 | Handler receive accepts |

## Verification
Two functions meet in the same cycle in two ways. In the crossed loopback case, the handler-output tap feeds the handler receive input while the line-receive tap feeds the line transmit output, so both sinks move bytes together. In the arbitration case, two sources become ready for one free sink on the same clock edge. The crossed case is provoked by enabling both taps in loop-only mode with cells queued on both streams. It is judged by per-source scoreboards on each sink and by a count of cycles in which both sinks transfer. The arbitration case is provoked by pushing cells into two sources at the same time. It is judged by which source's tag heads the first cell on the shared sink, and by the loser's ready staying low while the winner's cell is in flight.

// File: rtl/cell_loop_pkg.sv
package cell_loop_pkg;

    localparam int NUM_STREAMS = 3;
    localparam int NUM_PORTS   = 3;

    // source stream indices (also the tie-break order)
    localparam int SRC_BUF = 0;
    localparam int SRC_TXO = 1;
    localparam int SRC_RXL = 2;

    // sink indices
    localparam int DST_HTI = 0;
    localparam int DST_LTX = 1;
    localparam int DST_HRX = 2;

    typedef enum logic [1:0] {
        TAP_OFF  = 2'b00,
        TAP_ONLY = 2'b01,
        TAP_FWD  = 2'b10,
        TAP_RSVD = 2'b11
    } tap_mode_e;

    typedef logic [NUM_PORTS-1:0] dst_mask_t;

    function automatic logic tap_looping(logic [1:0] mode);
        return (mode == TAP_ONLY) || (mode == TAP_FWD);
    endfunction

    // sink set a stream feeds under a given tap setting
    function automatic dst_mask_t route_of(int src, logic [1:0] mode);
        dst_mask_t normal_m;
        dst_mask_t loop_m;
        normal_m = '0;
        loop_m   = '0;
        case (src)
            SRC_BUF: begin normal_m[DST_HTI] = 1'b1; loop_m[DST_HRX] = 1'b1; end
            SRC_TXO: begin normal_m[DST_LTX] = 1'b1; loop_m[DST_HRX] = 1'b1; end
            default: begin normal_m[DST_HRX] = 1'b1; loop_m[DST_LTX] = 1'b1; end
        endcase
        case (mode)
            TAP_ONLY: return loop_m;
            TAP_FWD:  return loop_m | normal_m;
            default:  return normal_m;
        endcase
    endfunction

endpackage

// File: rtl/cell_loop_fork.sv
module cell_loop_fork #(
    parameter int CELL_BYTES = 53,
    parameter int NUM_DST    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grant_i,
    input  logic [NUM_DST-1:0] grant_mask_i,
    input  logic               src_valid_i,
    input  logic [NUM_DST-1:0] dst_ready_i,
    output logic               busy_o,
    output logic [NUM_DST-1:0] mask_o,
    output logic [NUM_DST-1:0] dst_valid_o,
    output logic               src_pop_o,
    output logic               first_o
);

    localparam int CNT_W = (CELL_BYTES > 1) ? $clog2(CELL_BYTES) : 1;
    localparam int LAST  = CELL_BYTES - 1;

    typedef struct packed {
        logic               busy;
        logic [NUM_DST-1:0] mask;
        logic [NUM_DST-1:0] done;
        logic [CNT_W-1:0]   cnt;
    } fork_state_t;

    fork_state_t st_d, st_q;
    logic [NUM_DST-1:0] valid_c;
    logic               all_taken_c;
    logic               pop_c;

    always_comb begin
        valid_c     = {NUM_DST{st_q.busy & src_valid_i}} & st_q.mask & ~st_q.done;
        all_taken_c = &(~st_q.mask | st_q.done | dst_ready_i);
        pop_c       = st_q.busy & src_valid_i & all_taken_c;
        st_d        = st_q;
        if (!st_q.busy) begin
            if (grant_i) begin
                st_d.busy = 1'b1;
                st_d.mask = grant_mask_i;
                st_d.done = '0;
                st_d.cnt  = '0;
            end
        end else if (pop_c) begin
            st_d.done = '0;
            if (st_q.cnt == CNT_W'(LAST)) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.done = st_q.done | (valid_c & dst_ready_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o      = st_q.busy;
    assign mask_o      = st_q.mask;
    assign dst_valid_o = valid_c;
    assign src_pop_o   = pop_c;
    assign first_o     = (st_q.cnt == '0);

    // a sink that already took the byte must be one of the granted sinks
    assert_done_in_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done & ~st_q.mask) == '0);

    // the allocator never hands a new cell to a stream mid-cell
    assert_grant_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |-> !st_q.busy);

endmodule

// File: rtl/cell_loop_alloc.sv
module cell_loop_alloc #(
    parameter int NUM_SRC = 3,
    parameter int NUM_DST = 3
) (
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] loop_i,
    input  logic [NUM_DST-1:0] want_i [NUM_SRC],
    input  logic [NUM_DST-1:0] held_i,
    output logic [NUM_SRC-1:0] grant_o
);

    logic [NUM_DST-1:0] claimed_c;

    // Pass 0 serves looping streams, pass 1 the rest, index order inside a pass.
    // A pending stream claims its sinks even when blocked, so lower ranks
    // cannot take them and a cell is granted only with all its sinks at once.
    always_comb begin
        claimed_c = held_i;
        grant_o   = '0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (pend_i[s] && (loop_i[s] == (pass == 0))) begin
                    if ((want_i[s] & claimed_c) == '0) begin
                        grant_o[s] = 1'b1;
                    end
                    claimed_c = claimed_c | want_i[s];
                end
            end
        end
    end

endmodule

// File: rtl/cell_loop_ctrl.sv
module cell_loop_ctrl
    import cell_loop_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CELL_BYTES = 53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_tap_buf,
    input  logic [1:0]        cfg_tap_txo,
    input  logic [1:0]        cfg_tap_rxl,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              buf_empty,
    output logic              buf_rd,
    input  logic [DATA_W-1:0] txo_data,
    input  logic              txo_soc,
    input  logic              txo_valid,
    output logic              txo_ready,
    input  logic [DATA_W-1:0] rxl_data,
    input  logic              rxl_soc,
    input  logic              rxl_valid,
    output logic              rxl_ready,
    output logic [DATA_W-1:0] hti_data,
    output logic              hti_soc,
    output logic              hti_valid,
    input  logic              hti_ready,
    output logic [DATA_W-1:0] ltx_data,
    output logic              ltx_soc,
    output logic              ltx_valid,
    input  logic              ltx_ready,
    output logic [DATA_W-1:0] hrx_data,
    output logic              hrx_soc,
    output logic              hrx_valid,
    input  logic              hrx_ready
);

    logic [DATA_W-1:0]    src_data  [NUM_STREAMS];
    logic [NUM_STREAMS-1:0] src_valid;
    logic [1:0]           tap_mode  [NUM_STREAMS];
    logic [NUM_PORTS-1:0] want      [NUM_STREAMS];
    logic [NUM_STREAMS-1:0] pend, looping, grant, busy, pop, first;
    logic [NUM_PORTS-1:0] fk_mask   [NUM_STREAMS];
    logic [NUM_PORTS-1:0] fk_valid  [NUM_STREAMS];
    logic [NUM_PORTS-1:0] held;
    logic [NUM_PORTS-1:0] port_ready;
    logic [NUM_PORTS-1:0] out_valid, out_soc;
    logic [DATA_W-1:0]    out_data  [NUM_PORTS];
    logic [NUM_STREAMS-1:0] owner   [NUM_PORTS];

    always_comb begin
        src_data[SRC_BUF]  = buf_data;
        src_data[SRC_TXO]  = txo_data;
        src_data[SRC_RXL]  = rxl_data;
        src_valid[SRC_BUF] = ~buf_empty;
        src_valid[SRC_TXO] = txo_valid;
        src_valid[SRC_RXL] = rxl_valid;
        tap_mode[SRC_BUF]  = cfg_tap_buf;
        tap_mode[SRC_TXO]  = cfg_tap_txo;
        tap_mode[SRC_RXL]  = cfg_tap_rxl;
        port_ready[DST_HTI] = hti_ready;
        port_ready[DST_LTX] = ltx_ready;
        port_ready[DST_HRX] = hrx_ready;
    end

    always_comb begin
        for (int s = 0; s < NUM_STREAMS; s++) begin
            want[s]    = route_of(s, tap_mode[s]);
            looping[s] = tap_looping(tap_mode[s]);
            pend[s]    = src_valid[s] & ~busy[s];
        end
    end

    always_comb begin
        for (int o = 0; o < NUM_PORTS; o++) begin
            for (int s = 0; s < NUM_STREAMS; s++) begin
                owner[o][s] = busy[s] & fk_mask[s][o];
            end
            held[o] = |owner[o];
        end
    end

    cell_loop_alloc #(
        .NUM_SRC (NUM_STREAMS),
        .NUM_DST (NUM_PORTS)
    ) alloc_i (
        .pend_i  (pend),
        .loop_i  (looping),
        .want_i  (want),
        .held_i  (held),
        .grant_o (grant)
    );

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_fork
        cell_loop_fork #(
            .CELL_BYTES (CELL_BYTES),
            .NUM_DST    (NUM_PORTS)
        ) fork_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .grant_i      (grant[s]),
            .grant_mask_i (want[s]),
            .src_valid_i  (src_valid[s]),
            .dst_ready_i  (port_ready),
            .busy_o       (busy[s]),
            .mask_o       (fk_mask[s]),
            .dst_valid_o  (fk_valid[s]),
            .src_pop_o    (pop[s]),
            .first_o      (first[s])
        );

        // a cell is granted only onto sinks nobody holds
        assert_grant_free_sinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
            grant[s] |-> ((want[s] & held) == '0));
    end

    always_comb begin
        for (int o = 0; o < NUM_PORTS; o++) begin
            out_data[o]  = '0;
            out_valid[o] = 1'b0;
            out_soc[o]   = 1'b0;
            for (int s = 0; s < NUM_STREAMS; s++) begin
                if (owner[o][s]) begin
                    out_data[o]  = src_data[s];
                    out_valid[o] = fk_valid[s][o];
                    out_soc[o]   = fk_valid[s][o] & first[s];
                end
            end
        end
    end

    assign buf_rd    = pop[SRC_BUF];
    assign txo_ready = pop[SRC_TXO];
    assign rxl_ready = pop[SRC_RXL];

    assign hti_data  = out_data[DST_HTI];
    assign hti_valid = out_valid[DST_HTI];
    assign hti_soc   = out_soc[DST_HTI];
    assign ltx_data  = out_data[DST_LTX];
    assign ltx_valid = out_valid[DST_LTX];
    assign ltx_soc   = out_soc[DST_LTX];
    assign hrx_data  = out_data[DST_HRX];
    assign hrx_valid = out_valid[DST_HRX];
    assign hrx_soc   = out_soc[DST_HRX];

    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_port_chk
        assert_single_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(owner[o]));

        assert_hold_until_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && !port_ready[o]) |=> (out_valid[o] && $stable(out_data[o])));
    end

    assert_read_only_when_filled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |-> !buf_empty);

    assert_txo_cell_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (txo_valid && !busy[SRC_TXO]) |-> txo_soc);

    assert_rxl_cell_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rxl_valid && !busy[SRC_RXL]) |-> rxl_soc);

endmodule

// File: tb/cell_loop_ctrl_tb.sv
module cell_loop_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CELL       = 53;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [1:0] cfg_buf = 2'b00, cfg_txo = 2'b00, cfg_rxl = 2'b00;
    logic [7:0] buf_data = '0;
    logic       buf_empty = 1'b1;
    logic       buf_rd;
    logic [7:0] txo_data = '0;
    logic       txo_soc = 1'b0, txo_valid = 1'b0, txo_ready;
    logic [7:0] rxl_data = '0;
    logic       rxl_soc = 1'b0, rxl_valid = 1'b0, rxl_ready;
    logic [7:0] hti_data, ltx_data, hrx_data;
    logic       hti_soc, hti_valid, ltx_soc, ltx_valid, hrx_soc, hrx_valid;
    logic       hti_ready = 1'b1, ltx_ready = 1'b1, hrx_ready = 1'b1;

    cell_loop_ctrl #(.DATA_W(8), .CELL_BYTES(CELL)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_tap_buf(cfg_buf), .cfg_tap_txo(cfg_txo), .cfg_tap_rxl(cfg_rxl),
        .buf_data(buf_data), .buf_empty(buf_empty), .buf_rd(buf_rd),
        .txo_data(txo_data), .txo_soc(txo_soc), .txo_valid(txo_valid), .txo_ready(txo_ready),
        .rxl_data(rxl_data), .rxl_soc(rxl_soc), .rxl_valid(rxl_valid), .rxl_ready(rxl_ready),
        .hti_data(hti_data), .hti_soc(hti_soc), .hti_valid(hti_valid), .hti_ready(hti_ready),
        .ltx_data(ltx_data), .ltx_soc(ltx_soc), .ltx_valid(ltx_valid), .ltx_ready(ltx_ready),
        .hrx_data(hrx_data), .hrx_soc(hrx_soc), .hrx_valid(hrx_valid), .hrx_ready(hrx_ready)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // source models and expected queues: exq[sink][source]
    logic [7:0] bq[$], tq[$], rq[$];
    logic       tsq[$], rsq[$];
    logic [7:0] exq [3][3][$];
    int         seq_no [3] = '{0, 0, 0};
    int         rx_idx [3] = '{0, 0, 0};
    int         rx_src [3] = '{0, 0, 0};
    int         rcv_cnt [3] = '{0, 0, 0};
    int         first_src [3] = '{-1, -1, -1};
    bit         arm_first [3] = '{0, 0, 0};
    int         sink_mode [3] = '{0, 0, 0};
    bit         src_stall = 1'b0;
    int         both_cnt = 0;
    bit         fire_b = 0, fire_t = 0, fire_r = 0;
    logic [15:0] lf = 16'hACE1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cell_byte(int s, int sq, int k);
        if (k == 0) return {2'(s), 6'(sq)};
        return 8'(sq * 13 + k * 5 + s * 71);
    endfunction

    // sinks: bit0 handler-tx-in, bit1 line-tx, bit2 handler-rx
    function automatic logic [2:0] bench_route(int s, logic [1:0] m);
        logic [2:0] nrm, lp;
        nrm = (s == 0) ? 3'b001 : (s == 1) ? 3'b010 : 3'b100;
        lp  = (s == 2) ? 3'b010 : 3'b100;
        if (m == 2'b01) return lp;
        if (m == 2'b10) return lp | nrm;
        return nrm;
    endfunction

    task automatic send_cell(input int s);
        logic [1:0] m;
        logic [2:0] r;
        m = (s == 0) ? cfg_buf : (s == 1) ? cfg_txo : cfg_rxl;
        r = bench_route(s, m);
        for (int k = 0; k < CELL; k++) begin
            logic [7:0] b;
            b = cell_byte(s, seq_no[s], k);
            if (s == 0) bq.push_back(b);
            else if (s == 1) begin tq.push_back(b); tsq.push_back(k == 0); end
            else begin rq.push_back(b); rsq.push_back(k == 0); end
            for (int o = 0; o < 3; o++) if (r[o]) exq[o][s].push_back(b);
        end
        seq_no[s] = (seq_no[s] + 1) % 64;
    endtask

    // driver: apply pops decided at the previous negedge, then present next values
    always @(posedge clk) begin
        #1;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (fire_b && bq.size() != 0) void'(bq.pop_front());
        if (fire_t && tq.size() != 0) begin void'(tq.pop_front()); void'(tsq.pop_front()); end
        if (fire_r && rq.size() != 0) begin void'(rq.pop_front()); void'(rsq.pop_front()); end
        buf_empty = (bq.size() == 0);
        buf_data  = (bq.size() != 0) ? bq[0] : 8'h00;
        if (!(txo_valid && !fire_t)) txo_valid = (tq.size() != 0) && (src_stall ? lf[1] : 1'b1);
        txo_data = (tq.size() != 0) ? tq[0] : 8'h00;
        txo_soc  = (tsq.size() != 0) ? tsq[0] : 1'b0;
        if (!(rxl_valid && !fire_r)) rxl_valid = (rq.size() != 0) && (src_stall ? lf[4] : 1'b1);
        rxl_data = (rq.size() != 0) ? rq[0] : 8'h00;
        rxl_soc  = (rsq.size() != 0) ? rsq[0] : 1'b0;
        hti_ready = (sink_mode[0] == 0) ? 1'b1 : (sink_mode[0] == 1) ? lf[7]  : 1'b0;
        ltx_ready = (sink_mode[1] == 0) ? 1'b1 : (sink_mode[1] == 1) ? lf[9]  : 1'b0;
        hrx_ready = (sink_mode[2] == 0) ? 1'b1 : (sink_mode[2] == 1) ? lf[11] : 1'b0;
    end

    task automatic take(input int o, input logic [7:0] d, input logic soc);
        int s;
        if (rx_idx[o] == 0) begin
            s = int'(d[7:6]);
            if (s > 2) s = 2;
            rx_src[o] = s;
            chk(soc == 1'b1, "R7 start flag on byte 0", soc, 1);
            if (arm_first[o]) begin first_src[o] = s; arm_first[o] = 0; end
        end else begin
            chk(soc == 1'b0, "R7 start flag off after byte 0", soc, 0);
        end
        s = rx_src[o];
        if (exq[o][s].size() == 0) begin
            chk(1'b0, $sformatf("R2 unexpected byte on sink %0d from source %0d", o, s), d, -1);
        end else begin
            logic [7:0] e;
            e = exq[o][s].pop_front();
            chk(d == e, $sformatf("R6 data on sink %0d from source %0d", o, s), d, e);
        end
        rx_idx[o] = (rx_idx[o] + 1) % CELL;
        rcv_cnt[o]++;
    endtask

    // monitor: sample away from the rising edge
    always @(negedge clk) begin
        fire_b = rst_n && buf_rd && !buf_empty;
        fire_t = rst_n && txo_valid && txo_ready;
        fire_r = rst_n && rxl_valid && rxl_ready;
        if (rst_n) begin
            if (hti_valid && hti_ready) take(0, hti_data, hti_soc);
            if (ltx_valid && ltx_ready) take(1, ltx_data, ltx_soc);
            if (hrx_valid && hrx_ready) take(2, hrx_data, hrx_soc);
            if (ltx_valid && ltx_ready && hrx_valid && hrx_ready) both_cnt++;
        end
    end

    function automatic bit all_empty();
        if (bq.size() != 0 || tq.size() != 0 || rq.size() != 0) return 0;
        for (int o = 0; o < 3; o++)
            for (int s = 0; s < 3; s++)
                if (exq[o][s].size() != 0) return 0;
        return 1;
    endfunction

    task automatic drain(input string req);
        int left;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (all_empty()) break;
        end
        left = 0;
        for (int o = 0; o < 3; o++)
            for (int s = 0; s < 3; s++) left += exq[o][s].size();
        chk(all_empty(), {req, " all expected bytes delivered"}, left, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
        summary();
        $finish;
    end

    initial begin
        int base;
        // R11: reset state
        repeat (4) @(negedge clk);
        chk(!hti_valid && !ltx_valid && !hrx_valid, "R11 sinks idle in reset",
            {hti_valid, ltx_valid, hrx_valid}, 0);
        chk(!buf_rd, "R11 no buffer read in reset", buf_rd, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: all taps off, random sink stalls and source gaps
        sink_mode = '{1, 1, 1};
        src_stall = 1'b1;
        for (int i = 0; i < 2; i++) begin send_cell(0); send_cell(1); send_cell(2); end
        drain("R2");

        // R1: reserved code acts as off
        cfg_buf = 2'b11; cfg_txo = 2'b11; cfg_rxl = 2'b11;
        send_cell(0); send_cell(1); send_cell(2);
        drain("R1");

        // R3: buffer tap loop only, other paths normal
        cfg_buf = 2'b01; cfg_txo = 2'b00; cfg_rxl = 2'b00;
        for (int i = 0; i < 3; i++) begin send_cell(0); send_cell(2); end
        send_cell(1);
        drain("R3");

        // R4: handler output tap loop only (cells of any content, idle included)
        cfg_buf = 2'b00; cfg_txo = 2'b01;
        send_cell(1); send_cell(1);
        drain("R4");

        // R5: line receive tap loop only
        cfg_txo = 2'b00; cfg_rxl = 2'b01;
        send_cell(2); send_cell(2);
        drain("R5");

        // R6: all taps loop and forward
        cfg_buf = 2'b10; cfg_txo = 2'b10; cfg_rxl = 2'b10;
        for (int i = 0; i < 2; i++) begin send_cell(0); send_cell(1); send_cell(2); end
        drain("R6");

        // R6: a stalled sink holds the forwarded twin at byte 0
        cfg_txo = 2'b00; cfg_rxl = 2'b00;
        src_stall = 1'b0;
        sink_mode = '{2, 0, 0};
        base = rcv_cnt[2];
        send_cell(0);
        repeat (20) @(negedge clk);
        chk(rcv_cnt[2] - base == 1, "R6 lockstep with stalled twin", rcv_cnt[2] - base, 1);
        chk(bq.size() == CELL, "R6 buffer not advanced", bq.size(), CELL);
        sink_mode = '{0, 0, 0};
        drain("R6");

        // R8 + R9: looping buffer beats normal line receive on handler rx
        cfg_buf = 2'b01; cfg_txo = 2'b00; cfg_rxl = 2'b00;
        arm_first[2] = 1;
        send_cell(0); send_cell(2);
        repeat (6) @(negedge clk);
        chk(rxl_valid && !rxl_ready, "R9 displaced stream held", rxl_ready, 0);
        drain("R8");
        chk(first_src[2] == 0, "R8 loop beats normal on handler rx", first_src[2], 0);

        // R8: looping line receive beats normal handler output on line tx
        cfg_buf = 2'b00; cfg_rxl = 2'b01;
        arm_first[1] = 1;
        send_cell(1); send_cell(2);
        drain("R8");
        chk(first_src[1] == 2, "R8 loop beats normal on line tx", first_src[1], 2);

        // R8: two looping taps tie-break by index
        cfg_buf = 2'b01; cfg_txo = 2'b01; cfg_rxl = 2'b00;
        arm_first[2] = 1;
        send_cell(1); send_cell(0);
        drain("R8");
        chk(first_src[2] == 0, "R8 tie order buffer first", first_src[2], 0);

        // R9: sink held off, nothing lost
        cfg_buf = 2'b00; cfg_txo = 2'b00; cfg_rxl = 2'b00;
        sink_mode = '{0, 0, 2};
        send_cell(2); send_cell(2);
        repeat (200) @(negedge clk);
        chk(hrx_valid == 1'b1, "R9 sink valid held", hrx_valid, 1);
        chk(rxl_ready == 1'b0, "R9 source backpressured", rxl_ready, 0);
        sink_mode = '{0, 0, 0};
        drain("R9");

        // R10: crossed loopbacks run together
        cfg_txo = 2'b01; cfg_rxl = 2'b01;
        base = both_cnt;
        for (int i = 0; i < 4; i++) begin send_cell(1); send_cell(2); end
        drain("R10");
        chk(both_cnt - base > 0, "R10 both sinks moving in one cycle", both_cnt - base, 1);

        // R7: setting changed mid-cell applies from the next cell
        cfg_txo = 2'b00; cfg_rxl = 2'b00;
        sink_mode = '{0, 0, 1};
        base = rcv_cnt[2];
        send_cell(2);
        while (rcv_cnt[2] == base) @(negedge clk);
        cfg_rxl = 2'b01;
        send_cell(2);
        drain("R7");
        chk(rcv_cnt[2] - base == CELL, "R7 first cell whole on old route", rcv_cnt[2] - base, CELL);

        summary();
        $finish;
    end

endmodule